// File: doc/BRIEF.md
# Interrupt Pin Delivery Engine

This block sits between the interrupt sources of a chip and the per-core interrupt controllers. It serves 32 interrupt pins. Each pin has a routing entry that gives its vector, destination, addressing flag, delivery mode, trigger kind and mask. Sources report assert, deassert or pulse events per pin. For each pin the block keeps a saturating count of outstanding asserts. When a pin's count rises from zero to one, the block tries to deliver a message.

Masked pins drop the attempt. A level-triggered pin stays blocked after a delivery until an end-of-interrupt (EOI) arrives for its vector. The EOI sweeps the pins one per cycle and clears the blocking flag on every pin whose vector matches. Any such pin that is still asserted fires again. Outputs are a one-cycle message strobe with its fields, one-cycle error pulses, and three running statistics counters.

Top module: `pin_delivery_engine`

## Requirements
- R1: After reset every routing entry is masked, all counts are zero, busy and dlv_valid are low and ev_ready is high, all statistics read zero, and an assert on a pin that has not been written produces no message.
- R2: An assert event (ev_op 0) adds one to the pin's count. When the count goes from 0 to 1 on an unmasked pin, a message is sent with dlv_valid high in the cycle after acceptance. The message fields come from tbl_data as written: vector from bits 7:0, mode from bits 10:8, dest from bits 63:56, dlv_phys high when bit 11 is clear, and dlv_level equal to bit 15.
- R3: A deassert event (ev_op 1) subtracts one from the count and never sends. A count that returns to 0 and then rises to 1 again sends again. A rise from 1 to 2 sends nothing.
- R4: An assert at count 255 leaves the count unchanged and raises err_sat_hi. A deassert at count 0 leaves it unchanged and raises err_sat_lo. Each error lasts one cycle.
- R5: A pulse event (ev_op 2) is an assert followed by a deassert in the same cycle. It sends if the count was 0 and leaves the count unchanged. If the assert saturates, the deassert is skipped and only err_sat_hi is raised.
- R6: An attempt on an entry whose mask bit 16 is set sends nothing and leaves the pin unblocked.
- R7: A level-triggered pin (bit 15 set) becomes blocked when a message is sent. While blocked, further attempts send nothing. Edge-triggered pins never block.
- R8: An accepted EOI (eoi_valid while busy is low) holds busy high for 32 cycles and visits pin p in cycle p+1 after acceptance. A blocked pin whose vector equals eoi_vec is unblocked there. If its count is nonzero it is re-attempted, and any resulting message appears in cycle p+1. Pins with other vectors stay blocked.
- R9: ev_ready is low while busy, eoi_valid or tbl_we is high. tbl_we and eoi_valid are ignored while busy. EOI takes priority over a table write in the same cycle.
- R10: A table write (tbl_we, tbl_pin, tbl_data) replaces the pin's entry. Data bits 12 and 14 have no effect on blocking. Writing an edge entry unblocks the pin. Writing a level entry while the pin's count is nonzero makes an immediate attempt, which appears as a message in the next cycle.
- R11: An event with ev_pin of 32 or more, or with ev_op 3, raises err_pin for one cycle, sends nothing and changes no count.
- R12: stat_sent counts messages sent. stat_sat_hi and stat_sat_lo count high and low saturation errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Pin event request |
| ev_ready | output | 1 | Pin event accepted when high with ev_valid |
| ev_pin | input | 6 | Pin number of the event |
| ev_op | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 invalid |
| tbl_we | input | 1 | Routing entry write strobe |
| tbl_pin | input | 5 | Pin whose entry is written |
| tbl_data | input | 64 | New routing entry |
| eoi_valid | input | 1 | End-of-interrupt broadcast |
| eoi_vec | input | 8 | Vector of the EOI |
| busy | output | 1 | EOI sweep in progress |
| dlv_valid | output | 1 | Message strobe, one cycle |
| dlv_vector | output | 8 | Message vector |
| dlv_dest | output | 8 | Message destination |
| dlv_phys | output | 1 | Physical addressing when high |
| dlv_mode | output | 3 | Delivery mode |
| dlv_level | output | 1 | Level-triggered source |
| err_sat_hi | output | 1 | Count saturated high |
| err_sat_lo | output | 1 | Count saturated low |
| err_pin | output | 1 | Invalid pin or opcode |
| stat_sent | output | 32 | Messages sent |
| stat_sat_hi | output | 32 | High saturation events |
| stat_sat_lo | output | 32 | Low saturation events |

## Verification
The properties assume that rst_n is low from time zero. They also assume that an EOI seen while the block is idle always starts a sweep, which holds only because EOI outranks table writes and pin events. The stimulus issues one event, table write or EOI at a time and waits for busy to fall before starting the next. The one exception is a single table write placed deliberately inside a sweep to show that it is ignored. Counts are driven to both limits so that the saturation and pulse-skip rules are exercised at their boundaries.

// File: rtl/pin_delivery_engine.sv
module pin_delivery_engine #(
  parameter int NPIN   = 32,
  parameter int CNT_W  = 8,
  parameter int STAT_W = 32,
  localparam int PIN_W = $clog2(NPIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [PIN_W:0]    ev_pin,
  input  logic [1:0]        ev_op,
  input  logic              tbl_we,
  input  logic [PIN_W-1:0]  tbl_pin,
  input  logic [63:0]       tbl_data,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vec,
  output logic              busy,
  output logic              dlv_valid,
  output logic [7:0]        dlv_vector,
  output logic [7:0]        dlv_dest,
  output logic              dlv_phys,
  output logic [2:0]        dlv_mode,
  output logic              dlv_level,
  output logic              err_sat_hi,
  output logic              err_sat_lo,
  output logic              err_pin,
  output logic [STAT_W-1:0] stat_sent,
  output logic [STAT_W-1:0] stat_sat_hi,
  output logic [STAT_W-1:0] stat_sat_lo
);
  // stored entry: {dest[21:14], mask[13], level[12], logical[11], mode[10:8], vec[7:0]}
  localparam int EW = 22;
  localparam logic [EW-1:0]    ENT_RST = 22'h2000;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PIN_W:0]   NPIN_L  = (PIN_W+1)'(NPIN);
  localparam logic [PIN_W-1:0] LAST    = PIN_W'(NPIN - 1);

  logic [EW-1:0]    ent_q [NPIN];
  logic [CNT_W-1:0] cnt_q [NPIN];
  logic [NPIN-1:0]  irr_q;
  logic             scan_q;
  logic [PIN_W-1:0] idx_q;
  logic [7:0]       vec_q;

  logic             unused_bits;
  assign unused_bits = ^{tbl_data[55:17], tbl_data[14:12]};

  wire [EW-1:0] tw_ent = {tbl_data[63:56], tbl_data[16], tbl_data[15], tbl_data[11],
                          tbl_data[10:8], tbl_data[7:0]};

  assign busy     = scan_q;
  assign ev_ready = !scan_q && !eoi_valid && !tbl_we;

  wire eoi_go = eoi_valid && !scan_q;
  wire tw_go  = tbl_we && !scan_q && !eoi_valid;
  wire ev_go  = ev_valid && ev_ready;

  wire [PIN_W-1:0] evp  = ev_pin[PIN_W-1:0];
  wire [CNT_W-1:0] ev_c = cnt_q[evp];

  logic [PIN_W-1:0] pin;
  logic [EW-1:0]    ent;
  logic             irr_in, try_dlv, irr_we, cnt_we, hi, lo, bad, send, irr_nx;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    pin = '0; ent = ent_q[0]; irr_in = 1'b0; try_dlv = 1'b0; irr_we = 1'b0;
    cnt_we = 1'b0; cnt_nx = '0; hi = 1'b0; lo = 1'b0; bad = 1'b0;
    if (scan_q) begin
      pin = idx_q;
      ent = ent_q[idx_q];
      if (irr_q[idx_q] && ent_q[idx_q][7:0] == vec_q) begin
        irr_we  = 1'b1;
        try_dlv = cnt_q[idx_q] != '0;
      end
    end else if (tw_go) begin
      pin     = tbl_pin;
      ent     = tw_ent;
      irr_we  = 1'b1;
      irr_in  = irr_q[tbl_pin] && tbl_data[15];
      try_dlv = tbl_data[15] && cnt_q[tbl_pin] != '0;
    end else if (ev_go) begin
      if (ev_pin >= NPIN_L || ev_op == 2'd3) begin
        bad = 1'b1;
      end else begin
        pin    = evp;
        ent    = ent_q[evp];
        irr_in = irr_q[evp];
        case (ev_op)
          2'd0: if (ev_c == CNT_MAX) hi = 1'b1;
                else begin cnt_we = 1'b1; cnt_nx = ev_c + CNT_ONE; try_dlv = ev_c == '0; end
          2'd1: if (ev_c == '0) lo = 1'b1;
                else begin cnt_we = 1'b1; cnt_nx = ev_c - CNT_ONE; end
          default: if (ev_c == CNT_MAX) hi = 1'b1;
                   else try_dlv = ev_c == '0;
        endcase
      end
    end
    send   = try_dlv && !ent[13] && !(ent[12] && irr_in);
    irr_nx = irr_in || (send && ent[12]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIN; i++) begin
        ent_q[i] <= ENT_RST;
        cnt_q[i] <= '0;
      end
      irr_q       <= '0;
      scan_q      <= 1'b0;
      idx_q       <= '0;
      vec_q       <= '0;
      dlv_valid   <= 1'b0;
      dlv_vector  <= '0;
      dlv_dest    <= '0;
      dlv_phys    <= 1'b0;
      dlv_mode    <= '0;
      dlv_level   <= 1'b0;
      err_sat_hi  <= 1'b0;
      err_sat_lo  <= 1'b0;
      err_pin     <= 1'b0;
      stat_sent   <= '0;
      stat_sat_hi <= '0;
      stat_sat_lo <= '0;
    end else begin
      dlv_valid  <= send;
      err_sat_hi <= hi;
      err_sat_lo <= lo;
      err_pin    <= bad;
      if (send) begin
        dlv_vector <= ent[7:0];
        dlv_mode   <= ent[10:8];
        dlv_phys   <= !ent[11];
        dlv_level  <= ent[12];
        dlv_dest   <= ent[21:14];
      end
      if (cnt_we) cnt_q[pin] <= cnt_nx;
      if (irr_we || send) irr_q[pin] <= irr_nx;
      if (tw_go) ent_q[tbl_pin] <= tw_ent;
      stat_sent   <= stat_sent   + {{(STAT_W-1){1'b0}}, send};
      stat_sat_hi <= stat_sat_hi + {{(STAT_W-1){1'b0}}, hi};
      stat_sat_lo <= stat_sat_lo + {{(STAT_W-1){1'b0}}, lo};
      if (eoi_go) begin
        scan_q <= 1'b1;
        idx_q  <= '0;
        vec_q  <= eoi_vec;
      end else if (scan_q) begin
        if (idx_q == LAST) scan_q <= 1'b0;
        idx_q <= idx_q + PIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/pin_delivery_engine_chk.sv
module pin_delivery_engine_chk #(
  parameter int NPIN   = 32,
  parameter int STAT_W = 32,
  localparam int PIN_W = $clog2(NPIN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [PIN_W:0]    ev_pin,
  input logic              eoi_valid,
  input logic              busy,
  input logic              dlv_valid,
  input logic              err_sat_hi,
  input logic              err_sat_lo,
  input logic              err_pin,
  input logic [STAT_W-1:0] stat_sent,
  input logic [STAT_W-1:0] stat_sat_hi
);
  localparam logic [PIN_W:0] NPIN_L = (PIN_W+1)'(NPIN);

  // R9
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_ready);

  // R8
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !busy) |=> busy);

  // R4
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_sat_hi, err_sat_lo, err_pin}));

  // R12
  sent_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sent == $past(stat_sent) + STAT_W'(dlv_valid));

  // R12
  hi_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sat_hi == $past(stat_sat_hi) + STAT_W'(err_sat_hi));

  // R11
  bad_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_pin >= NPIN_L) |=> (err_pin && !dlv_valid));
endmodule

bind pin_delivery_engine pin_delivery_engine_chk u_chk (.*);

// File: tb/pin_delivery_engine_test.sv
module pin_delivery_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, tbl_we = 1'b0, eoi_valid = 1'b0;
  logic [5:0] ev_pin = '0;
  logic [1:0] ev_op = '0;
  logic [4:0] tbl_pin = '0;
  logic [63:0] tbl_data = '0;
  logic [7:0] eoi_vec = '0;
  logic ev_ready, busy, dlv_valid, dlv_phys, dlv_level;
  logic [7:0] dlv_vector, dlv_dest;
  logic [2:0] dlv_mode;
  logic err_sat_hi, err_sat_lo, err_pin;
  logic [31:0] stat_sent, stat_sat_hi, stat_sat_lo;

  pin_delivery_engine uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_cyc = -1;
  int nsent = 0, nhi = 0, nlo = 0;
  logic [20:0] exp_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected messages as the design produces them
  always @(negedge clk) begin
    if (rst_n && dlv_valid) begin
      logic [20:0] got;
      got = {dlv_level, dlv_phys, dlv_mode, dlv_dest, dlv_vector};
      checks++;
      last_cyc = cyc;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected message %h, expected none", got);
      end else begin
        logic [20:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          fails++;
          $display("FAIL %s: message %h, expected %h", t, got, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h, expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                     input bit logical, input bit level, input bit mask,
                                     input logic [7:0] dest);
    return {dest, 39'd0, mask, level, 3'b000, logical, mode, vec};
  endfunction

  function automatic logic [20:0] msg(input logic [7:0] vec, input logic [2:0] mode,
                                      input bit logical, input bit level, input logic [7:0] dest);
    return {level, !logical, mode, dest, vec};
  endfunction

  task automatic expect_msg(input logic [20:0] m, input string tag);
    exp_q.push_back(m);
    tag_q.push_back(tag);
    nsent++;
  endtask

  task automatic ev(input logic [5:0] pin, input logic [1:0] op,
                    input bit e_hi, input bit e_lo, input bit e_bad, input string tag);
    @(negedge clk);
    chk(ev_ready, {tag, " ready"}, 32'(ev_ready), 1);
    ev_valid = 1'b1; ev_pin = pin; ev_op = op;
    @(negedge clk);
    ev_valid = 1'b0;
    chk({err_pin, err_sat_lo, err_sat_hi} == {e_bad, e_lo, e_hi}, tag,
        32'({err_pin, err_sat_lo, err_sat_hi}), 32'({e_bad, e_lo, e_hi}));
    nhi += int'(e_hi);
    nlo += int'(e_lo);
  endtask

  task automatic tw(input logic [4:0] pin, input logic [63:0] data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_pin = pin; tbl_data = data;
    #1 chk(!ev_ready, "R9 write holds off events", 32'(ev_ready), 0);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] vec, input int fire_pin, input bit poke);
    int n, acc;
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vec = vec;
    #1 chk(!ev_ready, "R9 eoi holds off events", 32'(ev_ready), 0);
    @(negedge clk);
    eoi_valid = 1'b0;
    acc = cyc;
    last_cyc = -1;
    chk(busy, "R8 busy after eoi", 32'(busy), 1);
    n = 0;
    while (busy && n < 40) begin
      n++;
      if (poke && n == 2) begin
        tbl_we = 1'b1; tbl_pin = 5'd5; tbl_data = mk(8'h41, 3'd2, 0, 0, 1, 8'hA5);
      end else begin
        tbl_we = 1'b0;
      end
      @(negedge clk);
    end
    tbl_we = 1'b0;
    chk(n == 32, "R8 sweep length", 32'(n), 32);
    if (fire_pin >= 0)
      chk(last_cyc == acc + 1 + fire_pin, "R8 refire cycle", 32'(last_cyc), 32'(acc + 1 + fire_pin));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !dlv_valid && ev_ready, "R1 idle after reset", 32'({busy, dlv_valid, ev_ready}), 1);
    chk(stat_sent == 0 && stat_sat_hi == 0 && stat_sat_lo == 0, "R1 stats zero",
        stat_sent | stat_sat_hi | stat_sat_lo, 0);
    ev(6'd3, 2'd0, 0, 0, 0, "R1 masked at reset");
    ev(6'd3, 2'd1, 0, 0, 0, "R1");

    // R2, R3 edge pin
    tw(5'd5, mk(8'h41, 3'd2, 0, 0, 0, 8'hA5));
    expect_msg(msg(8'h41, 3'd2, 0, 0, 8'hA5), "R2");
    ev(6'd5, 2'd0, 0, 0, 0, "R2 first assert");
    ev(6'd5, 2'd0, 0, 0, 0, "R3 second assert silent");
    ev(6'd5, 2'd1, 0, 0, 0, "R3");
    ev(6'd5, 2'd1, 0, 0, 0, "R3");
    expect_msg(msg(8'h41, 3'd2, 0, 0, 8'hA5), "R3 reassert");
    ev(6'd5, 2'd0, 0, 0, 0, "R3 reassert");
    ev(6'd5, 2'd1, 0, 0, 0, "R3");

    // R7 level blocking
    tw(5'd7, mk(8'h60, 3'd1, 1, 1, 0, 8'h3C));
    expect_msg(msg(8'h60, 3'd1, 1, 1, 8'h3C), "R7");
    ev(6'd7, 2'd0, 0, 0, 0, "R7 level send");
    ev(6'd7, 2'd1, 0, 0, 0, "R7");
    ev(6'd7, 2'd0, 0, 0, 0, "R7 blocked");

    // R8 sweep
    eoi(8'h61, -1, 0);
    expect_msg(msg(8'h60, 3'd1, 1, 1, 8'h3C), "R8 refire");
    eoi(8'h60, 7, 1);
    // R9: write during sweep had no effect, pin 5 still unmasked
    expect_msg(msg(8'h41, 3'd2, 0, 0, 8'hA5), "R9 write ignored while busy");
    ev(6'd5, 2'd0, 0, 0, 0, "R9");
    ev(6'd5, 2'd1, 0, 0, 0, "R9");
    ev(6'd7, 2'd1, 0, 0, 0, "R8");
    eoi(8'h60, -1, 0);
    expect_msg(msg(8'h60, 3'd1, 1, 1, 8'h3C), "R8 unblocked");
    ev(6'd7, 2'd0, 0, 0, 0, "R8 unblocked");

    // R10 table writes
    tw(5'd7, mk(8'h60, 3'd1, 1, 0, 0, 8'h3C));
    expect_msg(msg(8'h60, 3'd1, 1, 1, 8'h3C), "R10 level write fires");
    tw(5'd7, mk(8'h60, 3'd1, 1, 1, 0, 8'h3C));
    ev(6'd7, 2'd1, 0, 0, 0, "R10");
    tw(5'd9, mk(8'h70, 3'd0, 0, 1, 0, 8'h11) | 64'h5000);
    expect_msg(msg(8'h70, 3'd0, 0, 1, 8'h11), "R10 bits 12 14 ignored");
    ev(6'd9, 2'd0, 0, 0, 0, "R10");
    ev(6'd9, 2'd1, 0, 0, 0, "R10");

    // R6 mask
    tw(5'd10, mk(8'h22, 3'd0, 0, 1, 1, 8'h77));
    ev(6'd10, 2'd0, 0, 0, 0, "R6 masked");
    expect_msg(msg(8'h22, 3'd0, 0, 1, 8'h77), "R6 not blocked by masked attempt");
    tw(5'd10, mk(8'h22, 3'd0, 0, 1, 0, 8'h77));
    ev(6'd10, 2'd1, 0, 0, 0, "R6");

    // R4, R5 saturation and pulse
    tw(5'd12, mk(8'h12, 3'd4, 0, 0, 0, 8'hC3));
    expect_msg(msg(8'h12, 3'd4, 0, 0, 8'hC3), "R5 pulse");
    ev(6'd12, 2'd2, 0, 0, 0, "R5 pulse");
    ev(6'd12, 2'd1, 0, 1, 0, "R5 pulse leaves count");
    for (int i = 0; i < 255; i++) begin
      if (i == 0) expect_msg(msg(8'h12, 3'd4, 0, 0, 8'hC3), "R4");
      ev(6'd12, 2'd0, 0, 0, 0, "R4 count up");
    end
    ev(6'd12, 2'd0, 1, 0, 0, "R4 high saturation");
    ev(6'd12, 2'd2, 1, 0, 0, "R5 pulse at max");
    for (int i = 0; i < 255; i++) ev(6'd12, 2'd1, 0, 0, 0, "R5 deassert skipped");
    ev(6'd12, 2'd1, 0, 1, 0, "R4 low saturation");

    // R11
    ev(6'd40, 2'd0, 0, 0, 1, "R11 pin out of range");
    ev(6'd63, 2'd2, 0, 0, 1, "R11 pin out of range");
    ev(6'd12, 2'd3, 0, 0, 1, "R11 bad opcode");
    ev(6'd12, 2'd1, 0, 1, 0, "R11 count unchanged");

    // R12
    repeat (2) @(negedge clk);
    chk(stat_sent == 32'(nsent), "R12 sent", stat_sent, 32'(nsent));
    chk(stat_sat_hi == 32'(nhi), "R12 high", stat_sat_hi, 32'(nhi));
    chk(stat_sat_lo == 32'(nlo), "R12 low", stat_sat_lo, 32'(nlo));
    chk(exp_q.size() == 0, "R2 all expected messages seen", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule